// File: doc/BRIEF.md
# Dual-Channel Sampling Converter Serial Port Model

This block is a synthesizable stand-in for the digital side of a two-channel sampling converter. It is meant to sit opposite a host controller under test. A falling edge on the active-low start input latches both 12-bit sample words at the same moment, from input ports. It then raises a busy flag for a fixed number of system clock cycles, which stands in for the conversion time. There is no analog path: the sample words are whatever the surrounding test harness puts on the sample ports.

The host reads results over a chip-select/serial-clock link. Each of the two data pins has its own output enable, which stands in for a high-impedance driver. When chip select drops, both pins turn on and show their channel's MSB. Each later serial clock falling edge moves both pins one bit toward the LSB. If chip select stays low past the twelfth bit, each pin goes on with the other channel's word, so a host that wires up only one pin can still collect both results. After 24 bits the pins hold zero. All inputs are sampled by the system clock, and their edges are found by comparing each input with its value one cycle earlier.

Top module: `adc_emu_dual_serial`

## Requirements
- R1: The cycle after a falling edge of `conv_n` is seen while `busy` is low, `busy` is high.
- R2: `busy` stays high for exactly `CONV_CYCLES` consecutive system clock cycles per accepted start, and then returns low.
- R3: The cycle after a falling edge of `cs_n` is seen, both output enables are 1 and each pin shows bit 11 of its own channel's captured sample (pin A shows channel A, pin B shows channel B). This also holds when chip select falls while `busy` is still high.
- R4: While `cs_n` is low, each falling edge of `sclk` advances both pins by one bit position, from MSB toward LSB.
- R5: With `cs_n` still low, bit positions 12 through 23 of the stream carry the other channel's captured word, MSB first: channel B on pin A and channel A on pin B.
- R6: The cycle after `cs_n` is seen high, both output enables are 0. A later chip-select fall restarts the stream at the MSB.
- R7: A falling edge of `sclk` seen in the same cycle as the falling edge of `cs_n` does not advance the stream, so the MSB is still presented.
- R8: From bit position 24 onward, both pins drive 0 with their enables still 1, until chip select rises.
- R9: A falling edge of `conv_n` while `busy` is high is ignored. The captured samples do not change and the busy period is not lengthened.
- R10: Both sample words are captured in the cycle the accepted start edge is seen. Later changes on `samp_a` or `samp_b` do not alter the read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_n | input | 1 | Active-low conversion start; falling edge begins a conversion |
| cs_n | input | 1 | Active-low chip select for the serial read |
| sclk | input | 1 | Serial clock; falling edges shift the data pins |
| samp_a | input | 12 | Channel A sample word to capture |
| samp_b | input | 12 | Channel B sample word to capture |
| busy | output | 1 | High while the modelled conversion is in progress |
| dout_a | output | 1 | Pin A data value |
| dout_a_oe | output | 1 | Pin A drive enable (0 models high impedance) |
| dout_b | output | 1 | Pin B data value |
| dout_b_oe | output | 1 | Pin B drive enable (0 models high impedance) |

## Verification
The hardest case to reach from the ports is a serial clock fall that lands in the very same sampled cycle as the chip select fall. The bench creates it by raising `sclk` one cycle early, then dropping `cs_n` and `sclk` together at one clock edge. It then checks that the MSB stays on both pins until the next separate clock fall. A second case that is hard to reach is a start request that arrives mid-conversion while the sample ports are already showing new words. The bench counts the busy cycles across that request and reads back the first words to confirm that the request was ignored.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  // Counter width able to hold the value n.
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Bit shown at stream position idx of a frame of `total` bits, MSB first.
  // Positions at or past the frame length give zero.
  function automatic logic frame_bit(input logic [63:0] frame,
                                     input int unsigned idx,
                                     input int unsigned total);
    logic [63:0] shifted;
    if (idx >= total) return 1'b0;
    shifted = frame >> (total - 1 - idx);
    return shifted[0];
  endfunction

endpackage

// File: rtl/adc_emu_edges.sv
module adc_emu_edges #(
  parameter int N = 3,
  parameter logic [N-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= cur;
  end

  for (genvar i = 0; i < N; i++) begin : g_fall
    assign fall[i] = prev_q[i] & ~cur[i];
  end
endmodule

// File: rtl/adc_emu_convert.sv
module adc_emu_convert
  import adc_emu_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_fall,
  input  logic [DATA_W-1:0] samp_a,
  input  logic [DATA_W-1:0] samp_b,
  output logic              busy,
  output logic [DATA_W-1:0] cap_a,
  output logic [DATA_W-1:0] cap_b
);
  localparam int CNT_W = cnt_bits(CONV_CYCLES);

  logic [CNT_W-1:0] left_q;
  logic             start;   // accepted start request

  assign start = conv_fall & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
      cap_a  <= '0;
      cap_b  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      left_q <= CNT_W'(CONV_CYCLES - 1);
      cap_a  <= samp_a;
      cap_b  <= samp_b;
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  // Independent count of consecutive busy cycles, for the length check.
  logic [CNT_W-1:0] hi_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_cnt_q <= '0;
    else if (busy) hi_cnt_q <= hi_cnt_q + 1'b1;
    else           hi_cnt_q <= '0;
  end

  assert_busy_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_fall && !busy) |=> busy);

  assert_busy_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (hi_cnt_q == CNT_W'(CONV_CYCLES)));

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cap_a) && $stable(cap_b)));
endmodule

// File: rtl/adc_emu_frame_ctl.sv
module adc_emu_frame_ctl
  import adc_emu_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cs_n,
  input  logic                                 cs_fall,
  input  logic                                 sclk_fall,
  output logic                                 active,
  output logic [cnt_bits(2*DATA_W)-1:0]        bit_idx
);
  localparam int IDX_W = cnt_bits(2 * DATA_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(2 * DATA_W);

  logic advance;   // a counted shift edge
  assign advance = active & sclk_fall & ~cs_fall & (bit_idx < LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      bit_idx <= '0;
    end else if (cs_n) begin
      active  <= 1'b0;
      bit_idx <= '0;
    end else if (cs_fall) begin
      active  <= 1'b1;
      bit_idx <= '0;
    end else if (advance) begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

  assert_cs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (active && bit_idx == '0));

  assert_shift_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cs_n && sclk_fall && bit_idx < LAST) |=>
      (32'(bit_idx) == 32'($past(bit_idx)) + 1));

  assert_coincident_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && sclk_fall) |=> (bit_idx == '0));

  assert_index_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= LAST);
endmodule

// File: rtl/adc_emu_dual_serial.sv
module adc_emu_dual_serial
  import adc_emu_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] samp_a,
  input  logic [DATA_W-1:0] samp_b,
  output logic              busy,
  output logic              dout_a,
  output logic              dout_a_oe,
  output logic              dout_b,
  output logic              dout_b_oe
);
  localparam int IDX_W   = cnt_bits(2 * DATA_W);
  localparam int FRAME_W = 2 * DATA_W;

  // Edge order in the sampled vector: [2]=conv_n, [1]=cs_n, [0]=sclk.
  logic [2:0] fall;
  logic       conv_fall, cs_fall, sclk_fall;

  adc_emu_edges #(.N(3), .IDLE(3'b110)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .cur  ({conv_n, cs_n, sclk}),
    .fall (fall)
  );
  assign conv_fall = fall[2];
  assign cs_fall   = fall[1];
  assign sclk_fall = fall[0];

  logic [DATA_W-1:0] cap_a, cap_b;

  adc_emu_convert #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_convert (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_fall(conv_fall),
    .samp_a   (samp_a),
    .samp_b   (samp_b),
    .busy     (busy),
    .cap_a    (cap_a),
    .cap_b    (cap_b)
  );

  logic             active;
  logic [IDX_W-1:0] bit_idx;

  adc_emu_frame_ctl #(.DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .cs_fall  (cs_fall),
    .sclk_fall(sclk_fall),
    .active   (active),
    .bit_idx  (bit_idx)
  );

  // Pin p leads with its own channel, then chains into the other one.
  logic [1:0] pin_d;
  for (genvar p = 0; p < 2; p++) begin : g_pin
    logic [DATA_W-1:0] lead, trail;
    logic [63:0]       frame;
    assign lead  = (p == 0) ? cap_a : cap_b;
    assign trail = (p == 0) ? cap_b : cap_a;
    assign frame = 64'({lead, trail});
    assign pin_d[p] = active & frame_bit(frame, 32'(bit_idx), FRAME_W);
  end

  assign dout_a    = pin_d[0];
  assign dout_b    = pin_d[1];
  assign dout_a_oe = active;
  assign dout_b_oe = active;

  assert_msb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (dout_a_oe && dout_b_oe &&
                 dout_a == cap_a[DATA_W-1] && dout_b == cap_b[DATA_W-1]));

  assert_chain_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_idx == IDX_W'(DATA_W)) |->
      (dout_a == cap_b[DATA_W-1] && dout_b == cap_a[DATA_W-1]));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!dout_a_oe && !dout_b_oe));

  assert_tail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_idx == IDX_W'(FRAME_W)) |-> (!dout_a && !dout_b));
endmodule

// File: tb/tb_adc_emu_dual_serial.sv
module tb_adc_emu_dual_serial;
  localparam int DW   = 12;
  localparam int CONV = 8;
  localparam int NVEC = 6;
  localparam int READ_LEN = 26;

  // Each entry: {channel A word, channel B word}
  localparam logic [2*DW-1:0] VEC [NVEC] = '{
    {12'hA5C, 12'h3F0}, {12'hFFF, 12'h000}, {12'h000, 12'hFFF},
    {12'h800, 12'h001}, {12'h123, 12'h456}, {12'h5A5, 12'hA5A}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic conv_n = 1'b1, cs_n = 1'b1, sclk = 1'b0;
  logic [DW-1:0] samp_a = '0, samp_b = '0;
  logic busy, dout_a, dout_a_oe, dout_b, dout_b_oe;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  adc_emu_dual_serial #(.DATA_W(DW), .CONV_CYCLES(CONV)) dut (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .cs_n(cs_n), .sclk(sclk),
    .samp_a(samp_a), .samp_b(samp_b), .busy(busy),
    .dout_a(dout_a), .dout_a_oe(dout_a_oe),
    .dout_b(dout_b), .dout_b_oe(dout_b_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected stream bit, worked out position by position.
  function automatic logic want_bit(input logic [DW-1:0] own, input logic [DW-1:0] other,
                                    input int k);
    if (k < DW)     return own[DW-1-k];
    if (k < 2 * DW) return other[2*DW-1-k];
    return 1'b0;
  endfunction

  // Start a conversion; return the number of sampled busy-high cycles.
  task automatic convert(input logic [DW-1:0] a, input logic [DW-1:0] b, output int hi);
    @(negedge clk);
    samp_a = a; samp_b = b; conv_n = 1'b0;
    @(negedge clk);
    conv_n = 1'b1;
    hi = 0;
    while (busy && hi < 1000) begin
      hi++;
      @(negedge clk);
    end
  endtask

  // One serial clock fall; the result is visible at the following negedge.
  task automatic pulse_sclk();
    sclk = 1'b1;
    @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_frame(input logic [DW-1:0] a, input logic [DW-1:0] b,
                            input int nbits, input string tag);
    cs_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      if (k > 0) pulse_sclk();
      check($sformatf("%s oe R3 bit %0d", tag, k), {30'd0, dout_a_oe, dout_b_oe}, 32'd3);
      check($sformatf("%s pin A R4/R5/R8 bit %0d", tag, k), 32'(dout_a), 32'(want_bit(a, b, k)));
      check($sformatf("%s pin B R4/R5/R8 bit %0d", tag, k), 32'(dout_b), 32'(want_bit(b, a, k)));
    end
    cs_n = 1'b1;
    @(negedge clk);
    check({tag, " release R6"}, {30'd0, dout_a_oe, dout_b_oe}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int hi;
    repeat (3) @(negedge clk);
    // Reset state
    check("reset busy R1", 32'(busy), 32'd0);
    check("reset oe R6", {30'd0, dout_a_oe, dout_b_oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      convert(VEC[v][2*DW-1:DW], VEC[v][DW-1:0], hi);
      check($sformatf("vec %0d busy length R2", v), 32'(hi), 32'(CONV));
      samp_a = ~VEC[v][2*DW-1:DW]; samp_b = ~VEC[v][DW-1:0];   // R10: must not matter
      read_frame(VEC[v][2*DW-1:DW], VEC[v][DW-1:0], READ_LEN, $sformatf("vec %0d R10", v));
    end

    // R1 and R9: start while busy is ignored
    @(negedge clk);
    samp_a = 12'h9C3; samp_b = 12'h24E; conv_n = 1'b0;
    @(negedge clk);
    conv_n = 1'b1;
    check("start raises busy R1", 32'(busy), 32'd1);
    hi = 1;
    @(negedge clk);
    samp_a = 12'h111; samp_b = 12'h222; conv_n = 1'b0;
    if (busy) hi++;
    @(negedge clk);
    conv_n = 1'b1;
    while (busy && hi < 1000) begin
      hi++;
      @(negedge clk);
    end
    check("busy not extended R9", 32'(hi), 32'(CONV));
    read_frame(12'h9C3, 12'h24E, 2 * DW, "ignored start R9");

    // R7: sclk fall coincident with cs fall is not counted
    sclk = 1'b1;
    @(negedge clk);
    cs_n = 1'b0; sclk = 1'b0;
    @(negedge clk);
    check("coincident edge pin A R7", 32'(dout_a), 32'(want_bit(12'h9C3, 12'h24E, 0)));
    check("coincident edge pin B R7", 32'(dout_b), 32'(want_bit(12'h24E, 12'h9C3, 0)));
    pulse_sclk();
    check("after coincident, pin A R7", 32'(dout_a), 32'(want_bit(12'h9C3, 12'h24E, 1)));
    check("after coincident, pin B R7", 32'(dout_b), 32'(want_bit(12'h24E, 12'h9C3, 1)));

    // R6: abort mid-frame, then a fresh read restarts at the MSB
    pulse_sclk(); pulse_sclk();
    cs_n = 1'b1;
    @(negedge clk);
    check("abort release R6", {30'd0, dout_a_oe, dout_b_oe}, 32'd0);
    read_frame(12'h9C3, 12'h24E, 3, "restart R6");

    // R3: chip select dropped during busy shows the new capture's MSB
    @(negedge clk);
    samp_a = 12'h7FF; samp_b = 12'h800; conv_n = 1'b0;
    @(negedge clk);
    conv_n = 1'b1;
    cs_n = 1'b0;
    @(negedge clk);
    check("cs during busy R3 busy", 32'(busy), 32'd1);
    check("cs during busy R3 pin A", 32'(dout_a), 32'd0);
    check("cs during busy R3 pin B", 32'(dout_b), 32'd1);
    cs_n = 1'b1;
    repeat (CONV + 2) @(negedge clk);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule